// File: doc/BRIEF.md
# Vectored Interrupt Priority Nesting Unit

This block sits between the interrupt source logic and the processor's register bus of a vectored interrupt controller. It holds sixteen programmable vector slots. Each slot binds one of 32 interrupt sources to a handler address, and a separate fallback handler address covers every source with no slot. Slot position sets priority: slot 0 is the most urgent, the fallback level comes after slot 15, and an extra idle level means nothing is in service.

From the slot setup the unit derives, for every level, the set of sources that may pre-empt it. It sends the set for the level now in service to the routing block, which uses it to gate the processor's interrupt line. Software starts an interrupt service routine by reading the vector register. That read returns the handler address of the most urgent pending level, enters that level and remembers the level it left. The routine ends by writing any value to the same register, which brings back the level that was interrupted. Nested service is therefore tracked in hardware, one saved level per priority.

Top module: `vic_nest_unit`

## Requirements
- R1: Each slot control register keeps its low 8 bits. Bit 5 enables the slot and bits 4:0 name the source bound to it. A read returns those 8 bits with bits 31:8 as zero.
- R2: `curMask` is the OR of the one-hot source bits of every enabled slot whose index is below the current level. At level 0 it is zero, and at the idle level 17 it is all ones.
- R3: After reset the current level is 17 and `curMask` is all ones. Every slot address, every slot control and the fallback address read as zero.
- R4: A read of the vector register searches levels i = 0, 1, … below the current level for the first one where `rawStatus` AND the mask of level i+1 is nonzero. On a hit it returns the address of level i, saves the current level for level i and enters level i. `curMask` shows the new level from the next cycle.
- R5: At level 17 with nothing pending, a vector read returns the fallback address and leaves the level at 17.
- R6: When a level is in service and nothing more urgent is pending, a vector read returns the address of the current level and leaves the level unchanged.
- R7: A write of any value to the vector register restores the level saved for the current level. At level 17 it has no effect.
- R8: Register map (byte offsets): slot addresses at 0x100 + 4·n, slot controls at 0x200 + 4·n, vector register at 0x30, fallback address at 0x34 (read/write). The fallback address is also the handler address of level 16. Unmapped reads return zero.
- R9: A change to a slot control register changes the masks and the vector search from the next cycle.
- R10: Read data is combinational in the cycle of `rdEn`. The level change happens once, at the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Register byte offset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid while `rdEn` is high |
| rawStatus | input | 32 | Raw pending status of the 32 sources |
| curMask | output | 32 | Pre-emption mask of the level in service |

## Verification
The bench builds a nested service sequence: a low-urgency source is entered, a more urgent one pre-empts it, and two restore writes unwind the stack. A design that saved the wrong level would come back to idle too early, and `curMask` would show it. The level search is checked with no source pending, both at idle and while a level is in service. A design that entered a level on no pending source, or searched at or below the current level, would move the level or return the wrong address. A source with no enabled slot must land on the fallback level, where the mask differs from idle. Reprogramming a slot between accesses checks that the masks follow the control registers, and a stray restore write at idle must leave the mask all ones.

// File: rtl/vic_nest_pkg.sv
package vic_nest_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SLOT_ADDR,
    RD_SLOT_CTL,
    RD_DEFAULT,
    RD_VECTOR
  } rdSel_e;

  typedef struct packed {
    logic             wrSlotAddr;
    logic             wrSlotCtl;
    logic             wrDefault;
    logic [IDX_W-1:0] slotIdx;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] vecLevel;
  } vicStrobe_t;

endpackage

// File: rtl/vic_nest_datapath.sv
module vic_nest_datapath
  import vic_nest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  parameter int DATA_W    = 32,
  parameter int CTL_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  vicStrobe_t                 strb,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [$clog2(NUM_SLOTS+2)-1:0] curLevel,
  output logic [NUM_SLOTS+1:0][SRC_W-1:0] levelMasks,
  output logic [SRC_W-1:0]           curMask,
  output logic [DATA_W-1:0]          rdData
);

  localparam int SRC_IDX_W = $clog2(SRC_W);
  localparam int EN_BIT    = SRC_IDX_W;
  localparam int IDLE      = NUM_SLOTS + 1;

  logic [DATA_W-1:0] slotAddr [NUM_SLOTS];
  logic [CTL_W-1:0]  slotCtl  [NUM_SLOTS];
  logic [DATA_W-1:0] defAddr;

  // slot register file
  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : gSlot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotAddr[g] <= '0;
          slotCtl[g]  <= '0;
        end else begin
          if (strb.wrSlotAddr && strb.slotIdx == IDX_W'(g)) slotAddr[g] <= wrData;
          if (strb.wrSlotCtl  && strb.slotIdx == IDX_W'(g)) slotCtl[g]  <= wrData[CTL_W-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) defAddr <= '0;
    else if (strb.wrDefault) defAddr <= wrData;
  end

  // per-level pre-emption masks, accumulated slot by slot
  assign levelMasks[0] = '0;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : gMask
      logic [SRC_W-1:0] slotBit;
      always_comb begin
        slotBit = '0;
        if (slotCtl[g][EN_BIT]) slotBit[slotCtl[g][SRC_IDX_W-1:0]] = 1'b1;
      end
      assign levelMasks[g+1] = levelMasks[g] | slotBit;
    end
  endgenerate
  assign levelMasks[IDLE] = '1;

  assign curMask = levelMasks[curLevel];

  // read mux
  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_SLOT_ADDR: rdData = slotAddr[strb.slotIdx[$clog2(NUM_SLOTS)-1:0]];
      RD_SLOT_CTL:  rdData = DATA_W'(slotCtl[strb.slotIdx[$clog2(NUM_SLOTS)-1:0]]);
      RD_DEFAULT:   rdData = defAddr;
      RD_VECTOR: begin
        if (strb.vecLevel < IDX_W'(NUM_SLOTS))
          rdData = slotAddr[strb.vecLevel[$clog2(NUM_SLOTS)-1:0]];
        else
          rdData = defAddr;
      end
      default:      rdData = '0;
    endcase
  end

  // R2
  top_mask_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel == '0) |-> (curMask == '0));

endmodule

// File: rtl/vic_nest_ctrl.sv
module vic_nest_ctrl
  import vic_nest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [SRC_W-1:0]           rawStatus,
  input  logic [NUM_SLOTS+1:0][SRC_W-1:0] levelMasks,
  output logic [$clog2(NUM_SLOTS+2)-1:0] curLevel,
  output vicStrobe_t                 strb
);

  localparam int LVL_W     = $clog2(NUM_SLOTS + 2);
  localparam int IDLE      = NUM_SLOTS + 1;
  localparam int WORD_W    = ADDR_W - 2;
  localparam int SADDR_BASE = 'h100 >> 2;
  localparam int SCTL_BASE  = 'h200 >> 2;
  localparam int VEC_WORD   = 'h30 >> 2;
  localparam int DEF_WORD   = 'h34 >> 2;

  logic [WORD_W-1:0] word;
  logic              aligned, inSAddr, inSCtl, isVec, isDef;
  logic [IDX_W-1:0]  slotIdx;
  logic              rdVec, wrVec;
  logic              hitFound;
  logic [LVL_W-1:0]  hitLevel;
  logic [LVL_W-1:0]  prevLevel [NUM_SLOTS+1];

  // address decode
  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign inSAddr = aligned && word >= WORD_W'(SADDR_BASE) && word < WORD_W'(SADDR_BASE + NUM_SLOTS);
  assign inSCtl  = aligned && word >= WORD_W'(SCTL_BASE)  && word < WORD_W'(SCTL_BASE + NUM_SLOTS);
  assign isVec   = aligned && word == WORD_W'(VEC_WORD);
  assign isDef   = aligned && word == WORD_W'(DEF_WORD);

  always_comb begin
    if (inSCtl) slotIdx = IDX_W'(word - WORD_W'(SCTL_BASE));
    else        slotIdx = IDX_W'(word - WORD_W'(SADDR_BASE));
  end

  assign rdVec = rdEn && isVec;
  assign wrVec = wrEn && isVec;

  // search for the most urgent pending level above the current one
  always_comb begin
    hitFound = 1'b0;
    hitLevel = curLevel;
    for (int i = 0; i <= NUM_SLOTS; i++) begin
      if (!hitFound && LVL_W'(i) < curLevel && |(rawStatus & levelMasks[i+1])) begin
        hitFound = 1'b1;
        hitLevel = LVL_W'(i);
      end
    end
  end

  // strobes to the datapath
  always_comb begin
    strb            = '0;
    strb.slotIdx    = slotIdx;
    strb.vecLevel   = IDX_W'(hitLevel);
    strb.wrSlotAddr = wrEn && inSAddr;
    strb.wrSlotCtl  = wrEn && inSCtl;
    strb.wrDefault  = wrEn && isDef;
    strb.rdSel      = RD_NONE;
    if (rdEn) begin
      if (inSAddr)     strb.rdSel = RD_SLOT_ADDR;
      else if (inSCtl) strb.rdSel = RD_SLOT_CTL;
      else if (isDef)  strb.rdSel = RD_DEFAULT;
      else if (isVec)  strb.rdSel = RD_VECTOR;
    end
  end

  // in-service level and saved-level stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel <= LVL_W'(IDLE);
      for (int i = 0; i <= NUM_SLOTS; i++) prevLevel[i] <= LVL_W'(IDLE);
    end else if (rdVec) begin
      if (hitFound) begin
        prevLevel[hitLevel] <= curLevel;
        curLevel            <= hitLevel;
      end
    end else if (wrVec && curLevel != LVL_W'(IDLE)) begin
      curLevel <= prevLevel[curLevel];
    end
  end

  // R3
  legal_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    curLevel <= LVL_W'(IDLE));

  // R4
  enter_raises_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdVec && hitFound) |=> (curLevel < $past(curLevel)));

  // R5
  idle_empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdVec && curLevel == LVL_W'(IDLE) && rawStatus == '0) |=> (curLevel == LVL_W'(IDLE)));

  // R7
  pop_lowers_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrVec && !rdVec && curLevel != LVL_W'(IDLE)) |=> (curLevel > $past(curLevel)));

  // R7
  idle_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrVec && !rdVec && curLevel == LVL_W'(IDLE)) |=> $stable(curLevel));

endmodule

// File: rtl/vic_nest_unit.sv
module vic_nest_unit
  import vic_nest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [SRC_W-1:0]  rawStatus,
  output logic [SRC_W-1:0]  curMask
);

  localparam int LVL_W = $clog2(NUM_SLOTS + 2);

  vicStrobe_t                      strb;
  logic [LVL_W-1:0]                curLevel;
  logic [NUM_SLOTS+1:0][SRC_W-1:0] levelMasks;

  vic_nest_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .rawStatus(rawStatus), .levelMasks(levelMasks),
    .curLevel(curLevel), .strb(strb)
  );

  vic_nest_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .curLevel(curLevel), .levelMasks(levelMasks),
    .curMask(curMask), .rdData(rdData)
  );

endmodule

// File: tb/vic_nest_unit_tb.sv
module vic_nest_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] rawStatus = '0;
  logic [31:0] curMask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [11:0] VEC = 12'h030;
  localparam logic [11:0] DEF = 12'h034;

  always #4 clk = ~clk;

  vic_nest_unit u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rawStatus(rawStatus), .curMask(curMask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #2 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R3 idle mask", curMask, 32'hFFFF_FFFF);
    busRead(12'h100, d); check("R3 slot0 addr", d, 0);
    busRead(12'h23C, d); check("R3 slot15 ctl", d, 0);
    busRead(DEF, d);     check("R3 default addr", d, 0);
  endtask

  task automatic testConfig();
    logic [31:0] d;
    busWrite(12'h100, 32'hA000_0000); busWrite(12'h200, 32'h23);
    busWrite(12'h104, 32'hA000_0001); busWrite(12'h204, 32'h27);
    busWrite(12'h108, 32'hA000_0002); busWrite(12'h208, 32'h1F);
    busWrite(12'h10C, 32'hA000_0003); busWrite(12'h20C, 32'hFFFF_FF25);
    busWrite(DEF, 32'h0000_0DEF);
    busRead(12'h20C, d); check("R1 ctl readback 8 bits", d, 32'h25);
    busRead(12'h104, d); check("R8 slot1 addr offset", d, 32'hA000_0001);
    busRead(DEF, d);     check("R8 default addr", d, 32'hDEF);
    busRead(12'h3F0, d); check("R8 unmapped read", d, 0);
    check("R2 idle mask after config", curMask, 32'hFFFF_FFFF);
  endtask

  task automatic testIdleEmpty();
    logic [31:0] d;
    rawStatus = 0;
    busRead(VEC, d); check("R5 idle empty returns default", d, 32'hDEF);
    check("R5 level stays idle", curMask, 32'hFFFF_FFFF);
  endtask

  task automatic testNesting();
    logic [31:0] d;
    rawStatus = 32'h80;
    busRead(VEC, d); check("R4 enter level1 addr", d, 32'hA000_0001);
    check("R4 level1 mask", curMask, 32'h8);
    rawStatus = 32'h88;
    busRead(VEC, d); check("R4 pre-empt level0 addr", d, 32'hA000_0000);
    check("R2 level0 mask empty", curMask, 32'h0);
    busRead(VEC, d); check("R6 nothing higher returns current", d, 32'hA000_0000);
    check("R6 level unchanged", curMask, 32'h0);
    busWrite(VEC, 32'h1234);
    check("R7 pop to level1", curMask, 32'h8);
    busWrite(VEC, 32'h0);
    check("R10 single push per read, back to idle", curMask, 32'hFFFF_FFFF);
    busWrite(VEC, 32'h0);
    check("R7 write at idle ignored", curMask, 32'hFFFF_FFFF);
    rawStatus = 0;
  endtask

  task automatic testFallback();
    logic [31:0] d;
    rawStatus = 32'h8000_0000;
    busRead(VEC, d); check("R8 unassigned source uses default", d, 32'hDEF);
    check("R2 level16 mask", curMask, 32'h0000_00A8);
    busWrite(VEC, 0);
    check("R7 pop from level16", curMask, 32'hFFFF_FFFF);
    rawStatus = 32'h20;
    busRead(VEC, d); check("R1 slot3 bound to source5", d, 32'hA000_0003);
    check("R2 level3 mask", curMask, 32'h88);
    busWrite(VEC, 0);
    rawStatus = 0;
  endtask

  task automatic testRemap();
    logic [31:0] d;
    busWrite(12'h204, 32'h3F);
    rawStatus = 32'h8000_0000;
    busRead(VEC, d); check("R9 remapped slot1 hit", d, 32'hA000_0001);
    check("R9 level1 mask", curMask, 32'h8);
    busRead(VEC, d); check("R6 same level not re-entered", d, 32'hA000_0001);
    check("R6 level1 held", curMask, 32'h8);
    busWrite(VEC, 0);
    check("R7 back to idle", curMask, 32'hFFFF_FFFF);
    rawStatus = 0;
  endtask

  initial begin
    fork
      begin
        #1000000;
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testIdleEmpty();
    testNesting();
    testFallback();
    testRemap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule